// File: doc/BRIEF.md
# Fixed-Priority Task Selector with Counting Semaphores

This block offloads the bookkeeping of a small real-time kernel. It holds a table of task slots and a bank of signed 8-bit counting semaphores. At every moment it reports which slot should occupy the processor. Software issues one command at a time on a valid/ready port: create a task, load a semaphore, pend, post, enter an interrupt handler, leave an interrupt handler, or request a reschedule. When a reschedule selects a different slot, the block gives a one-cycle switch request. Software saves and restores the register context; that work is outside this block.

Slot 0 is the idle task and exists from reset. Each later task takes the next free slot, and a higher slot index means a higher priority, so the most recently created task always wins. The idle task can never block, so some task can always be selected. An interrupt nesting counter holds back every reschedule until the outermost handler exits.

Top module: `rtk_sched`

## Requirements
- R1: After reset, `cur_task` is 0 (the idle slot), only slot 0 exists, `switch_req` and `err` are 0, `cmd_ready` is 1, and every semaphore holds 0.
- R2: Opcode 0 (create) occupies the lowest free slot as READY. Because slot index is priority, the newest task ranks highest. Create does not reschedule. Opcode 6 (run) only reschedules. Opcode 7 does nothing.
- R3: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for the next cycle. A reschedule takes effect on the edge that ends that cycle. It selects the highest-index existing slot that is READY. `switch_req` is high for exactly that one cycle, and only if `cur_task` changed.
- R4: Opcode 2 (pend on `cmd_sem`) decrements the semaphore. If the value before the decrement was 0 or negative, the current task becomes blocked on that semaphore. A reschedule follows in either case.
- R5: Opcode 3 (post on `cmd_sem`) increments the semaphore. It then makes READY only the highest-index task blocked on that semaphore, and reschedules.
- R6: A post on a semaphore that has no blocked task changes no task status. The increased count lets the next pend pass without blocking.
- R7: Opcode 4 (interrupt enter) raises the nesting level. While the level is non-zero, `cur_task` does not change. Opcode 5 (interrupt exit) lowers the level and then reschedules, so only the outermost exit can switch.
- R8: The following commands are ignored and set the sticky `err` flag, which stays set until reset: a create when all slots are full, an exit at level 0, an enter at the maximum level, and a pend by the idle task that would block it.
- R9: Opcode 1 (load) writes the signed value `cmd_arg` into semaphore `cmd_sem`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 3 | Opcode: 0 create, 1 load, 2 pend, 3 post, 4 enter, 5 exit, 6 run, 7 none |
| cmd_sem | input | $clog2(NUM_SEMS) | Semaphore index for load, pend and post |
| cmd_arg | input | 8 | Signed load value |
| cur_task | output | $clog2(MAX_TASKS+1) | Slot chosen to run |
| switch_req | output | 1 | One-cycle pulse when `cur_task` changes |
| err | output | 1 | Sticky error flag |

## Verification
The checker runs on every cycle and covers these properties:
- `switch_req` and a change of `cur_task` occur together, in both directions.
- The block is busy for one cycle after each accepted command.
- `cur_task` always points at an existing slot.
- The idle slot is never blocked.
- `cur_task` holds while the interrupt level is non-zero.
- `err` never clears.

Some behaviour can only be shown by the bench's scenarios against its own model of slots and counts:
- which waiter a post wakes;
- whether a pend blocks, for each starting semaphore value;
- whether an ignored command really left the slot table and counts alone.

// File: rtl/rtk_pkg.sv
package rtk_pkg;
    typedef enum logic [2:0] {
        OP_CREATE = 3'd0,
        OP_LOAD   = 3'd1,
        OP_PEND   = 3'd2,
        OP_POST   = 3'd3,
        OP_ENTER  = 3'd4,
        OP_EXIT   = 3'd5,
        OP_RUN    = 3'd6,
        OP_NONE   = 3'd7
    } op_e;
endpackage

// File: rtl/rtk_hi_pick.sv
// Returns the index of the highest set request bit (highest priority).
module rtk_hi_pick #(
    parameter int N = 5,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    output logic [W-1:0] idx,
    output logic         any
);
    always_comb begin
        idx = '0;
        any = |req;
        for (int i = 0; i < N; i++) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/rtk_sched.sv
module rtk_sched #(
    parameter int MAX_TASKS = 4,
    parameter int NUM_SEMS  = 4,
    parameter int LVL_W     = 3,
    localparam int NSLOT    = MAX_TASKS + 1,
    localparam int TW       = $clog2(NSLOT),
    localparam int SW       = (NUM_SEMS > 1) ? $clog2(NUM_SEMS) : 1,
    localparam int CW       = $clog2(NSLOT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [2:0]    cmd_op,
    input  logic [SW-1:0] cmd_sem,
    input  logic [7:0]    cmd_arg,
    output logic [TW-1:0] cur_task,
    output logic          switch_req,
    output logic          err
);
    import rtk_pkg::*;

    typedef struct packed {
        logic [NSLOT-1:0]              blk;
        logic [NSLOT-1:0][SW-1:0]      wsem;
        logic [NUM_SEMS-1:0][7:0]      val;
        logic [CW-1:0]                 cnt;
        logic [LVL_W-1:0]              lvl;
        logic [TW-1:0]                 cur;
        logic                          busy;
        logic                          sched;
        logic                          sw;
        logic                          err;
    } st_t;

    st_t q, d;

    logic [NSLOT-1:0] rdy_vec, wait_vec;
    logic [TW-1:0]    run_idx, wake_idx;
    logic             run_any, wake_any;

    // Per-slot qualification vectors
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic exists;
        assign exists      = (CW'(g) < q.cnt);
        assign rdy_vec[g]  = exists && !q.blk[g];
        assign wait_vec[g] = exists && q.blk[g] && (q.wsem[g] == cmd_sem);
    end

    rtk_hi_pick #(.N(NSLOT), .W(TW)) u_run_pick (
        .req(rdy_vec), .idx(run_idx), .any(run_any)
    );

    rtk_hi_pick #(.N(NSLOT), .W(TW)) u_wake_pick (
        .req(wait_vec), .idx(wake_idx), .any(wake_any)
    );

    always_comb begin
        logic [7:0] old_v;
        d       = q;
        d.busy  = 1'b0;
        d.sched = 1'b0;
        d.sw    = 1'b0;
        old_v   = q.val[cmd_sem];
        if (q.busy) begin
            if (q.sched && q.lvl == '0 && run_any) begin
                d.cur = run_idx;
                d.sw  = (run_idx != q.cur);
            end
        end else if (cmd_valid) begin
            d.busy = 1'b1;
            case (op_e'(cmd_op))
                OP_CREATE: begin
                    if (q.cnt < CW'(NSLOT)) begin
                        for (int i = 0; i < NSLOT; i++)
                            if (CW'(i) == q.cnt) d.blk[i] = 1'b0;
                        d.cnt = q.cnt + 1'b1;
                    end else begin
                        d.err = 1'b1;
                    end
                end
                OP_LOAD: d.val[cmd_sem] = cmd_arg;
                OP_PEND: begin
                    if ($signed(old_v) <= 0 && q.cur == '0) begin
                        d.err = 1'b1;
                    end else begin
                        d.val[cmd_sem] = old_v - 8'd1;
                        d.sched        = 1'b1;
                        if ($signed(old_v) <= 0) begin
                            for (int i = 0; i < NSLOT; i++)
                                if (TW'(i) == q.cur) begin
                                    d.blk[i]  = 1'b1;
                                    d.wsem[i] = cmd_sem;
                                end
                        end
                    end
                end
                OP_POST: begin
                    d.val[cmd_sem] = old_v + 8'd1;
                    d.sched        = 1'b1;
                    if (wake_any)
                        for (int i = 0; i < NSLOT; i++)
                            if (TW'(i) == wake_idx) d.blk[i] = 1'b0;
                end
                OP_ENTER: begin
                    if (q.lvl == '1) d.err = 1'b1;
                    else             d.lvl = q.lvl + 1'b1;
                end
                OP_EXIT: begin
                    if (q.lvl == '0) begin
                        d.err = 1'b1;
                    end else begin
                        d.lvl   = q.lvl - 1'b1;
                        d.sched = 1'b1;
                    end
                end
                OP_RUN:  d.sched = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.cnt <= CW'(1);
        end else begin
            q <= d;
        end
    end

    assign cmd_ready  = !q.busy;
    assign cur_task   = q.cur;
    assign switch_req = q.sw;
    assign err        = q.err;
endmodule

// File: rtl/rtk_sched_chk.sv
module rtk_sched_chk #(
    parameter int TW    = 3,
    parameter int CW    = 3,
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [TW-1:0]    cur_task,
    input logic             switch_req,
    input logic             err,
    input logic             idle_blk,
    input logic [CW-1:0]    cnt,
    input logic [LVL_W-1:0] lvl
);
    a_r3_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
        switch_req |-> cur_task != $past(cur_task));
    a_r3_change_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_task != $past(cur_task)) |-> switch_req);
    a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
    a_r2_cur_exists: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cur_task) < int'(cnt));
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    a_r7_hold_in_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != '0) |=> $stable(cur_task));
    a_r4_idle_free: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_blk);
endmodule

bind rtk_sched rtk_sched_chk #(.TW(TW), .CW(CW), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cur_task(cur_task), .switch_req(switch_req), .err(err),
    .idle_blk(q.blk[0]), .cnt(q.cnt), .lvl(q.lvl)
);

// File: tb/rtk_sched_test.sv
`timescale 1ns/1ps
module rtk_sched_test;
    localparam int MAXT = 4;
    localparam int NS   = 4;
    localparam int LW   = 3;
    localparam int NSL  = MAXT + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [2:0] cmd_op = 3'd7;
    logic [1:0] cmd_sem = '0;
    logic [7:0] cmd_arg = '0;
    logic [2:0] cur_task;
    logic       switch_req;
    logic       err;

    int total = 0;
    int bad   = 0;

    // reference model
    bit  mb [NSL];
    int  ms [NSL];
    byte mv [NS];
    int  mcnt, mcur, mlvl;
    bit  merr, msw;

    always #4 clk = ~clk;

    rtk_sched #(.MAX_TASKS(MAXT), .NUM_SEMS(NS), .LVL_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_sem(cmd_sem), .cmd_arg(cmd_arg),
        .cur_task(cur_task), .switch_req(switch_req), .err(err)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NSL; i++) begin mb[i] = 0; ms[i] = 0; end
        for (int i = 0; i < NS; i++) mv[i] = 0;
        mcnt = 1; mcur = 0; mlvl = 0; merr = 0; msw = 0;
    endtask

    function automatic void model_sched();
        int pick;
        pick = 0;
        msw = 0;
        if (mlvl != 0) return;
        for (int i = 0; i < mcnt; i++) if (!mb[i]) pick = i;
        msw  = (pick != mcur);
        mcur = pick;
    endfunction

    function automatic void model_apply(input int op, input int s, input int v);
        byte old;
        msw = 0;
        case (op)
            0: if (mcnt < NSL) begin mb[mcnt] = 0; mcnt++; end else merr = 1;
            1: mv[s] = byte'(v);
            2: begin
                old = mv[s];
                if (old <= 0 && mcur == 0) merr = 1;
                else begin
                    mv[s] = old - 1;
                    if (old <= 0) begin mb[mcur] = 1; ms[mcur] = s; end
                    model_sched();
                end
            end
            3: begin
                int w;
                w = -1;
                mv[s] = mv[s] + 1;
                for (int i = 0; i < mcnt; i++) if (mb[i] && ms[i] == s) w = i;
                if (w >= 0) mb[w] = 0;
                model_sched();
            end
            4: if (mlvl == (1 << LW) - 1) merr = 1; else mlvl++;
            5: if (mlvl == 0) merr = 1; else begin mlvl--; model_sched(); end
            6: model_sched();
            default: ;
        endcase
    endfunction

    task automatic do_cmd(input int op, input int s, input int v, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_sem = 2'(s); cmd_arg = 8'(v);
        @(posedge clk); #1;
        cmd_valid = 1'b0; cmd_op = 3'd7;
        @(negedge clk);
        check({tag, " R3 busy"}, int'(cmd_ready), 0);
        model_apply(op, s, v);
        @(negedge clk);
        check({tag, " cur"}, int'(cur_task), mcur);
        check({tag, " R3 switch"}, int'(switch_req), int'(msw));
        check({tag, " R8 err"}, int'(err), int'(merr));
        @(negedge clk);
        check({tag, " R3 pulse end"}, int'(switch_req), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL R3 watchdog act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1 reset state
        @(negedge clk);
        check("R1 cur", int'(cur_task), 0);
        check("R1 switch", int'(switch_req), 0);
        check("R1 err", int'(err), 0);
        check("R1 ready", int'(cmd_ready), 1);
        // R1 semaphores start at 0: idle pend would block -> error
        do_cmd(2, 1, 0, "R1 sem zero");

        // R2 creation order and run
        do_reset();
        do_cmd(6, 0, 0, "R2 run idle only");
        do_cmd(0, 0, 0, "R2 create");
        check("R2 create no resched", int'(cur_task), 0);
        do_cmd(6, 0, 0, "R2 run");
        do_cmd(0, 0, 0, "R2 create");
        do_cmd(0, 0, 0, "R2 create");
        do_cmd(7, 0, 0, "R2 noop");
        do_cmd(6, 0, 0, "R2 run newest");
        check("R2 newest", int'(cur_task), 3);
        do_cmd(0, 0, 0, "R2 create last");
        do_cmd(0, 0, 0, "R8 create full");
        do_cmd(6, 0, 0, "R8 full ignored");
        check("R8 full cur", int'(cur_task), 4);

        // R6 post without waiter, then pend passes
        do_reset();
        do_cmd(0, 0, 0, "R6 create");
        do_cmd(6, 0, 0, "R6 run");
        do_cmd(3, 2, 0, "R6 post free");
        do_cmd(2, 2, 0, "R6 pend passes");
        check("R6 still running", int'(cur_task), 1);
        do_cmd(2, 2, 0, "R4 pend blocks");
        check("R4 blocked", int'(cur_task), 0);

        // R7 interrupt nesting
        do_reset();
        do_cmd(0, 0, 0, "R7 create");
        do_cmd(0, 0, 0, "R7 create");
        do_cmd(6, 0, 0, "R7 run");
        do_cmd(2, 0, 0, "R7 pend");
        do_cmd(4, 0, 0, "R7 enter");
        do_cmd(4, 0, 0, "R7 enter nested");
        do_cmd(3, 0, 0, "R7 post in isr");
        check("R7 held", int'(cur_task), 1);
        do_cmd(5, 0, 0, "R7 inner exit");
        check("R7 inner held", int'(cur_task), 1);
        do_cmd(5, 0, 0, "R7 outer exit");
        check("R7 outer switch", int'(cur_task), 2);
        do_cmd(5, 0, 0, "R8 exit at zero");
        do_reset();
        for (int i = 0; i < (1 << LW); i++) do_cmd(4, 0, 0, "R8 enter to max");
        for (int i = 0; i < (1 << LW) - 1; i++) do_cmd(5, 0, 0, "R8 unwind");
        do_cmd(5, 0, 0, "R8 exit extra");

        // R4 R5 R9 sweep over semaphores and start values
        for (int s = 0; s < NS; s++) begin
            for (int v = -2; v <= 2; v++) begin
                do_reset();
                for (int k = 0; k < MAXT; k++) do_cmd(0, 0, 0, "R2 sweep create");
                do_cmd(6, 0, 0, "R3 sweep run");
                do_cmd(1, s, v, "R9 load");
                for (int k = 0; k < 10 && mcur != 0; k++) do_cmd(2, s, 0, "R4 sweep pend");
                do_cmd(2, (s + 1) % NS, 0, "R8 idle pend");
                for (int k = 0; k < MAXT + 1; k++) do_cmd(3, s, 0, "R5 sweep post");
                check("R5 all woken", int'(cur_task), MAXT);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule